// File: doc/BRIEF.md
# Queue Event Interrupt Capture

This block watches three status flags on each of eight queues: a data-ready flag and two status flags, A and B. Each clock it compares every flag with a registered copy of that flag. It records four kinds of event per queue in a 32-bit sticky capture register: data-ready going high, data-ready going low, A going high and B going high. A captured bit stays set until the host reads the capture register. That read returns the current value and clears every bit it returned.

A 32-bit mask register selects which captured bits drive a single registered summary line to the host interrupt controller. The mask has no effect on capture or clearing. The host reaches both registers through a simple port with an address, a write strobe, a read strobe and read data. Read data is combinational from the address. A read strobe on the capture address clears that register at the next clock edge.

Top module: `qevt_irq_capture`

## Requirements
- R1: After reset, the capture register reads 0x00000000, the mask register reads 0x00000000 and `irq_out` is 0.
- R2: Queue n owns capture bits [4n+3:4n], so queue 0 is at [3:0] and queue 7 is at [31:28].
- R3: Inside a queue's nibble, bit 3 is data-ready rising, bit 2 is data-ready falling, bit 1 is flag A rising and bit 0 is flag B rising. Flags A and B going low set nothing.
- R4: An edge is found by comparing a flag with its value at the previous clock edge. A flag held at one level after an edge raises no further events.
- R5: A captured bit stays set over any number of cycles until the capture register is read.
- R6: A read strobe at address 0x1C0 returns the pre-clear capture value on `reg_rdata` in that cycle. All returned bits read 0 after the next clock edge.
- R7: An event detected in the same cycle as a capture read is set after that read, so it is not lost.
- R8: The mask register at address 0x1C4 is written by a write strobe with all 32 bits and reads back the written value.
- R9: A mask bit of 0 blocks only the summary: the bit under it is still captured, still read back and still cleared by a read.
- R10: `irq_out` is the OR over all bits of (capture AND mask), registered, so it follows a change of capture or mask by one clock cycle.
- R11: Writes to address 0x1C0 leave the capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy_flag | input | 8 | Data-ready flag per queue |
| stat_a | input | 8 | Status flag A per queue |
| stat_b | input | 8 | Status flag B per queue |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears capture on its address) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq_out | output | 1 | Registered masked interrupt summary |

## Verification
Single-flag stimulus on queue 0 checks the bit position of each event type. Stepping flags A, B and data-ready on queue 7 one at a time shows that the nibble order is correct and that A and B going low are ignored. A simultaneous edge on all eight queues catches swapped or shifted nibbles (0x88888888, then 0x44444444). A read in the same cycle as a fresh edge on another queue separates a correct clear from one that loses events. Mask tests use one masked event and one unmasked event. Changing the mask while a bit is set shows that the mask gates only the summary and that the summary lags by one cycle.

// File: rtl/qevt_irq_capture.sv
module qevt_irq_capture #(
  parameter int NQ = 8,
  parameter int AW = 12,
  parameter logic [AW-1:0] CAP_ADDR  = 12'h1C0,
  parameter logic [AW-1:0] MASK_ADDR = 12'h1C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     rdy_flag,
  input  logic [NQ-1:0]     stat_a,
  input  logic [NQ-1:0]     stat_b,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4*NQ-1:0]   reg_wdata,
  output logic [4*NQ-1:0]   reg_rdata,
  output logic              irq_out
);
  localparam int DW = 4 * NQ;

  logic [NQ-1:0] rdy_p, sa_p, sb_p;
  logic [DW-1:0] evt, cap_q, mask_q;
  logic          irq_q;

  wire cap_sel  = (reg_addr == CAP_ADDR);
  wire mask_sel = (reg_addr == MASK_ADDR);
  wire cap_clr  = reg_rd && cap_sel;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign evt[4*q+3] =  rdy_flag[q] & ~rdy_p[q];
    assign evt[4*q+2] = ~rdy_flag[q] &  rdy_p[q];
    assign evt[4*q+1] =  stat_a[q]   & ~sa_p[q];
    assign evt[4*q]   =  stat_b[q]   & ~sb_p[q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_p  <= '0;
      sa_p   <= '0;
      sb_p   <= '0;
      cap_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      rdy_p <= rdy_flag;
      sa_p  <= stat_a;
      sb_p  <= stat_b;
      cap_q <= (cap_clr ? '0 : cap_q) | evt;
      if (reg_wr && mask_sel) mask_q <= reg_wdata;
      irq_q <= |(cap_q & mask_q);
    end
  end

  assign reg_rdata = cap_sel ? cap_q : (mask_sel ? mask_q : '0);
  assign irq_out   = irq_q;

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_clr |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

  // R7
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((cap_q & $past(evt)) == $past(evt)));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_clr && evt == '0) |=> (cap_q == '0));

  // R11
  cap_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cap_sel && !reg_rd && evt == '0) |=> $stable(cap_q));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_out);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && mask_sel) |=> $stable(mask_q));
endmodule

// File: tb/qevt_irq_capture_test.sv
module qevt_irq_capture_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  rdy_flag = '0, stat_a = '0, stat_b = '0;
  logic [11:0] reg_addr = 12'h1C0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int          n_chk = 0, n_fail = 0;
  localparam logic [11:0] CAP = 12'h1C0, MSK = 12'h1C4;

  always #4 clk = ~clk;

  qevt_irq_capture uut (
    .clk(clk), .rst_n(rst_n), .rdy_flag(rdy_flag), .stat_a(stat_a), .stat_b(stat_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; reg_rd = 0; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic read_clear(input logic [31:0] exp, input string req);
    reg_addr = CAP; reg_rd = 1; #1;
    chk(req, reg_rdata, exp);
    tick();
    reg_rd = 0; #1;
    chk("R6 cleared", reg_rdata, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic t_reset;
    peek(CAP, 32'h0, "R1 capture");
    peek(MSK, 32'h0, "R1 mask");
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_q0_edges;
    rdy_flag[0] = 1; tick();
    peek(CAP, 32'h8, "R2 R3 rdy rise q0");
    tick(3);
    peek(CAP, 32'h8, "R4 R5 held level no new event");
    read_clear(32'h8, "R6 pre-clear value");
    tick(2);
    peek(CAP, 32'h0, "R4 level high no event");
    rdy_flag[0] = 0; tick();
    peek(CAP, 32'h4, "R3 rdy fall q0");
    read_clear(32'h4, "R6 fall read");
  endtask

  task automatic t_q7_nibble;
    stat_a[7] = 1; tick();
    peek(CAP, 32'h2000_0000, "R2 R3 A rise q7");
    stat_b[7] = 1; tick();
    peek(CAP, 32'h3000_0000, "R3 B rise q7");
    rdy_flag[7] = 1; tick();
    peek(CAP, 32'hB000_0000, "R3 rdy rise q7");
    stat_a[7] = 0; stat_b[7] = 0; tick();
    peek(CAP, 32'hB000_0000, "R3 A/B fall ignored");
    rdy_flag[7] = 0; tick();
    read_clear(32'hF000_0000, "R3 full nibble q7");
  endtask

  task automatic t_all_queues;
    rdy_flag = 8'hFF; tick();
    read_clear(32'h8888_8888, "R2 all queues rise");
    rdy_flag = 8'h00; tick();
    read_clear(32'h4444_4444, "R2 all queues fall");
  endtask

  task automatic t_read_race;
    stat_a[0] = 1; tick();
    peek(CAP, 32'h2, "R3 A rise q0");
    reg_addr = CAP; reg_rd = 1; stat_a[1] = 1; #1;
    chk("R6 race read value", reg_rdata, 32'h2);
    tick();
    reg_rd = 0; #1;
    chk("R7 event kept across read", reg_rdata, 32'h20);
    read_clear(32'h20, "R7 kept bit readable");
    stat_a = '0; tick();
    peek(CAP, 32'h0, "R3 A fall ignored");
  endtask

  task automatic t_cap_write;
    stat_b[2] = 1; tick();
    peek(CAP, 32'h100, "R2 B rise q2");
    wr(CAP, 32'hFFFF_FFFF);
    peek(CAP, 32'h100, "R11 write ones ignored");
    wr(CAP, 32'h0);
    peek(CAP, 32'h100, "R11 write zero ignored");
    read_clear(32'h100, "R6 after writes");
    stat_b = '0; tick();
  endtask

  task automatic t_mask;
    wr(MSK, 32'hA5A5_5A5A);
    peek(MSK, 32'hA5A5_5A5A, "R8 mask readback");
    wr(MSK, 32'h0000_00F0);
    peek(MSK, 32'h0000_00F0, "R8 mask rewrite");
    rdy_flag[0] = 1; tick();
    peek(CAP, 32'h8, "R9 masked bit captured");
    tick(2);
    chk("R9 masked no irq", {31'b0, irq_out}, 32'h0);
    read_clear(32'h8, "R9 masked bit clears");
    rdy_flag[1] = 1; tick();
    peek(CAP, 32'h80, "R2 rdy rise q1");
    chk("R10 irq lags one cycle", {31'b0, irq_out}, 32'h0);
    tick();
    chk("R10 irq asserted", {31'b0, irq_out}, 32'h1);
    reg_addr = CAP; reg_rd = 1; tick(); reg_rd = 0; #1;
    chk("R10 irq still high after clear edge", {31'b0, irq_out}, 32'h1);
    tick();
    chk("R10 irq drops", {31'b0, irq_out}, 32'h0);
    rdy_flag[1] = 0; tick(2);
    chk("R10 irq on fall q1", {31'b0, irq_out}, 32'h1);
    wr(MSK, 32'h0);
    chk("R10 irq old mask", {31'b0, irq_out}, 32'h1);
    tick();
    chk("R9 irq off by mask", {31'b0, irq_out}, 32'h0);
    peek(CAP, 32'h40, "R9 bit kept under mask");
    read_clear(32'h40, "R9 read clears masked");
  endtask

  initial begin
    tick(3);
    rst_n = 1; #1;
    t_reset();
    t_q0_edges();
    t_q7_nibble();
    t_all_queues();
    t_read_race();
    t_cap_write();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule